// File: doc/BRIEF.md
# Fixed-Point Format Converter

This block narrows a fixed-point sample from one binary format to another. Each format is fixed at compile time by three numbers: whether the word is two's complement or unsigned, how many bits it has, and how many of those bits sit right of the binary point. The default build takes a signed 16-bit word with 13 fraction bits to a signed 12-bit word with 9 fraction bits.

Two run-time selects travel with every sample. The first picks how the surplus fraction bits are removed: chopped off, or rounded by adding half an output LSB first. The second picks what happens when the result no longer fits the output's integer range: keep the low bits (wrap), clamp to the nearest representable extreme, or keep the low bits and raise an overflow flag for that sample. The overflow test is made on the value after rounding, so a rounding carry that pushes the result past the top of the range is caught.

The result, a valid flag and the overflow flag leave through a register pipeline whose depth is a parameter. One sample may enter on every clock.

Top module: `fxc_convert`

## Requirements
- R1: A sample captured with `vld_i` high at a rising edge appears on `dout_o`, with `vld_o` high, after exactly `LATENCY` rising edges counting the capture edge; one sample may be accepted on every cycle and `vld_o` repeats the `vld_i` pattern delayed by `LATENCY` cycles.
- R2: With `rnd_i` = 0 (truncate) the dropped fraction bits are discarded, so the result is the input value rounded toward minus infinity to the output LSB (signed 0xFFF7 in 16.13 gives 0xFFF in 12.9).
- R3: With `rnd_i` = 1 (round) half an output LSB is added before the bits are dropped, so an exact half rounds upward (signed 0xFFF8 in 16.13 gives 0x000 in 12.9, and 0x2348 gives 0x235).
- R4: Overflow is judged on the value after rounding: signed 0x7FFF in 16.13, rounded to 12.9, exceeds the output maximum and is treated as an overflow.
- R5: Overflow select `ovf_mode_i` = 2'b00 (wrap) outputs the low `OUT_W` bits of the scaled value and keeps `ovf_o` low.
- R6: `ovf_mode_i` = 2'b01 (saturate) outputs the largest representable output value on positive overflow and the smallest on negative overflow (0x7FF and 0x800 for a signed 12-bit output) and keeps `ovf_o` low.
- R7: `ovf_mode_i` = 2'b10 (flag) outputs the same data as wrap and drives `ovf_o` high together with `vld_o` for each overflowing sample only.
- R8: `ovf_mode_i` = 2'b11 behaves exactly like wrap.
- R9: `ovf_o` is never high while `vld_o` is low; a cycle with `vld_i` low never raises `ovf_o`, whatever its data and selects.
- R10: While `rst_n` is low, `vld_o`, `ovf_o` and `dout_o` are all zero.
- R11: Both selects are taken with each sample, so changing them on every cycle of a back-to-back stream converts each sample under its own selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Input sample valid |
| din_i | input | IN_W | Input fixed-point word |
| rnd_i | input | 1 | 0 truncate, 1 round half up |
| ovf_mode_i | input | 2 | 00 wrap, 01 saturate, 10 flag, 11 wrap |
| vld_o | output | 1 | Output sample valid |
| dout_o | output | OUT_W | Converted fixed-point word |
| ovf_o | output | 1 | Overflow raised for this sample in flag mode |

## Verification
The bench drives the input at the top of the range with rounding on, where the only overflow comes from the rounding carry; a design that tested the range before adding the half LSB would pass 0x7FF through silently instead of wrapping, clamping or flagging. Negative values just below and exactly at a half LSB separate floor truncation from truncation toward zero and half-up from half-down rounding, which a sign-magnitude or biased shortcut would get wrong by one LSB. A second instance with fewer integer bits pushes both extremes past the output range, exposing a saturation that picks the wrong bound or a flag that leaks into wrap and saturate modes. A back-to-back stream with selects changing each cycle and a bubble in the middle catches selects latched per burst instead of per sample and a valid or flag pipeline of the wrong depth.

// File: rtl/fxc_pkg.sv
package fxc_pkg;

  typedef enum logic [1:0] {
    OVF_WRAP = 2'b00,
    OVF_SAT  = 2'b01,
    OVF_FLAG = 2'b10,
    OVF_ALT  = 2'b11
  } ovf_mode_e;

  typedef enum logic {
    QNT_TRUNC = 1'b0,
    QNT_ROUND = 1'b1
  } qnt_mode_e;

  function automatic logic mode_clamps(input ovf_mode_e m);
    return (m == OVF_SAT);
  endfunction

  function automatic logic mode_raises(input ovf_mode_e m);
    return (m == OVF_FLAG);
  endfunction

endpackage

// File: rtl/fxc_quant.sv
module fxc_quant #(
  parameter int IN_W      = 16,
  parameter int IN_FRAC   = 13,
  parameter int IN_SIGNED = 1,
  parameter int OUT_FRAC  = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IN_W-1:0]        din,
  input  logic                   rnd,
  output logic signed [IN_W+1:0] q,
  output logic                   bump
);

  localparam int EW    = IN_W + 2;
  localparam int SHIFT = IN_FRAC - OUT_FRAC;

  // Place the raw word in a wider signed field with two guard bits.
  function automatic logic signed [EW-1:0] widen(input logic [IN_W-1:0] d);
    if (IN_SIGNED != 0) return {{2{d[IN_W-1]}}, d};
    else                return {2'b00, d};
  endfunction

  logic signed [EW-1:0] ext;
  logic signed [EW-1:0] q_floor;

  assign ext = widen(din);

  generate
    if (SHIFT == 0) begin : g_noshift
      assign q_floor = ext;
      assign q       = ext;
    end else begin : g_shift
      localparam logic signed [EW-1:0] HALF = EW'(1) << (SHIFT - 1);
      logic signed [EW-1:0] biased;
      assign biased  = rnd ? ext + HALF : ext;
      assign q       = biased >>> SHIFT;
      assign q_floor = ext >>> SHIFT;
    end
  endgenerate

  // Named event: rounding moved the result one step above the floor value.
  assign bump = (q != q_floor);

  // R2
  trunc_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rnd |-> !bump);

  // R3
  round_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bump |-> ((q - q_floor) == EW'(1)));

endmodule

// File: rtl/fxc_range.sv
module fxc_range #(
  parameter int EW         = 18,
  parameter int OUT_W      = 12,
  parameter int OUT_SIGNED = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [EW-1:0] q,
  input  logic                 clamp_en,
  output logic                 above,
  output logic                 below,
  output logic [OUT_W-1:0]     res
);

  localparam logic signed [EW-1:0] MAXV = (OUT_SIGNED != 0)
                                        ? (EW'(1) << (OUT_W - 1)) - EW'(1)
                                        : (EW'(1) << OUT_W) - EW'(1);
  localparam logic signed [EW-1:0] MINV = (OUT_SIGNED != 0) ? ~MAXV : '0;

  function automatic logic [OUT_W-1:0] fit(input logic signed [EW-1:0] v,
                                           input logic hi, input logic lo,
                                           input logic en);
    if (en && hi)      return MAXV[OUT_W-1:0];
    else if (en && lo) return MINV[OUT_W-1:0];
    else               return v[OUT_W-1:0];
  endfunction

  always_comb begin
    above = (q > MAXV);
    below = (q < MINV);
    res   = fit(q, above, below, clamp_en);
  end

  // R6
  bound_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({above, below}));

endmodule

// File: rtl/fxc_pipe.sv
module fxc_pipe #(
  parameter int W     = 14,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= d;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/fxc_convert.sv
module fxc_convert
  import fxc_pkg::*;
#(
  parameter int IN_W       = 16,
  parameter int IN_FRAC    = 13,
  parameter int IN_SIGNED  = 1,
  parameter int OUT_W      = 12,
  parameter int OUT_FRAC   = 9,
  parameter int OUT_SIGNED = 1,
  parameter int LATENCY    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [IN_W-1:0]  din_i,
  input  logic             rnd_i,
  input  logic [1:0]       ovf_mode_i,
  output logic             vld_o,
  output logic [OUT_W-1:0] dout_o,
  output logic             ovf_o
);

  localparam int EW = IN_W + 2;
  localparam int PW = OUT_W + 2;
  localparam int CW = $clog2(LATENCY + 1) + 1;

  ovf_mode_e            mode;
  logic signed [EW-1:0] scaled;
  logic                 rnd_bump;
  logic                 over_hi;
  logic                 over_lo;
  logic [OUT_W-1:0]     fitted;
  logic                 raise;
  logic [PW-1:0]        pipe_in;
  logic [PW-1:0]        pipe_out;

  assign mode = ovf_mode_e'(ovf_mode_i);

  fxc_quant #(
    .IN_W     (IN_W),
    .IN_FRAC  (IN_FRAC),
    .IN_SIGNED(IN_SIGNED),
    .OUT_FRAC (OUT_FRAC)
  ) u_quant (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (din_i),
    .rnd  (rnd_i),
    .q    (scaled),
    .bump (rnd_bump)
  );

  fxc_range #(
    .EW        (EW),
    .OUT_W     (OUT_W),
    .OUT_SIGNED(OUT_SIGNED)
  ) u_range (
    .clk     (clk),
    .rst_n   (rst_n),
    .q       (scaled),
    .clamp_en(mode_clamps(mode)),
    .above   (over_hi),
    .below   (over_lo),
    .res     (fitted)
  );

  assign raise   = vld_i && mode_raises(mode) && (over_hi || over_lo);
  assign pipe_in = {vld_i, raise, fitted};

  fxc_pipe #(
    .W    (PW),
    .DEPTH(LATENCY)
  ) u_pipe (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pipe_in),
    .q    (pipe_out)
  );

  assign vld_o  = pipe_out[PW-1];
  assign ovf_o  = pipe_out[PW-2];
  assign dout_o = pipe_out[OUT_W-1:0];

  // Samples accepted but not yet presented at the output.
  logic [CW-1:0] pend;
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend + CW'(vld_i) - CW'(vld_o);
  end

  // R1
  lat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= CW'(LATENCY));

  // R1
  out_has_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (pend != '0));

  // R9
  flag_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> vld_o);

  // R4
  carry_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_bump && over_hi) |-> rnd_i);

endmodule

// File: tb/fxc_convert_bench.sv
`timescale 1ns/1ps
module fxc_convert_bench;

  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld_i = 1'b0;
  logic [15:0] din = '0;
  logic        rnd = 1'b0;
  logic [1:0]  om = 2'b00;

  logic        vo_a, fo_a, vo_b, fo_b;
  logic [11:0] do_a, do_b;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  fxc_convert #(.LATENCY(LAT)) u_fxc_convert (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .din_i(din), .rnd_i(rnd),
    .ovf_mode_i(om), .vld_o(vo_a), .dout_o(do_a), .ovf_o(fo_a));

  fxc_convert #(.OUT_FRAC(10), .LATENCY(LAT)) u_narrow (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .din_i(din), .rnd_i(rnd),
    .ovf_mode_i(om), .vld_o(vo_b), .dout_o(do_b), .ovf_o(fo_b));

  // Integer model: scale by 2^-shift with optional half-LSB bias, then range handling.
  function automatic void model(input logic [15:0] d, input int shift,
                                input logic r, input logic [1:0] m,
                                output logic [11:0] y, output logic f);
    longint v, mx, mn;
    v = longint'($signed(d));
    if (r) v = v + (longint'(1) <<< (shift - 1));
    v  = v >>> shift;
    mx = 2047;
    mn = -2048;
    if (m == 2'b01 && v > mx)      y = 12'(mx);
    else if (m == 2'b01 && v < mn) y = 12'(mn);
    else                           y = 12'(v);
    f = (m == 2'b10) && (v > mx || v < mn);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Push one sample alone and compare both instances LAT edges later.
  task automatic one(input string tag, input logic [15:0] d, input logic r, input logic [1:0] m);
    logic [11:0] ya, yb;
    logic fa, fb;
    model(d, 4, r, m, ya, fa);
    model(d, 3, r, m, yb, fb);
    @(negedge clk);
    din = d; rnd = r; om = m; vld_i = 1'b1;
    @(posedge clk);
    #1 vld_i = 1'b0;
    repeat (LAT - 1) @(posedge clk);
    #2;
    check({tag, " R1 vld a"}, 32'(vo_a), 32'(1));
    check({tag, " data a"}, 32'(do_a), 32'(ya));
    check({tag, " flag a"}, 32'(fo_a), 32'(fa));
    check({tag, " data b"}, 32'(do_b), 32'(yb));
    check({tag, " flag b"}, 32'(fo_b), 32'(fb));
  endtask

  task automatic t_reset();
    // R10
    check("R10 vld", 32'(vo_a), 32'(0));
    check("R10 data", 32'(do_a), 32'(0));
    check("R10 flag", 32'(fo_a), 32'(0));
  endtask

  task automatic t_trunc();
    one("R2 pos", 16'h2348, 1'b0, 2'b00);
    one("R2 neg half", 16'hFFF8, 1'b0, 2'b00);
    one("R2 neg below", 16'hFFF7, 1'b0, 2'b00);
    check("R2 floor value", 32'(do_a), 32'h0FFF);
  endtask

  task automatic t_round();
    one("R3 pos up", 16'h2348, 1'b1, 2'b00);
    check("R3 pos up value", 32'(do_a), 32'h0235);
    one("R3 pos down", 16'h2347, 1'b1, 2'b00);
    one("R3 neg tie", 16'hFFF8, 1'b1, 2'b00);
    check("R3 tie up value", 32'(do_a), 32'h0000);
    one("R3 neg below", 16'hFFF7, 1'b1, 2'b00);
  endtask

  task automatic t_round_carry();
    one("R4 R5 carry wrap", 16'h7FFF, 1'b1, 2'b00);
    check("R4 wrap value", 32'(do_a), 32'h0800);
    one("R4 R6 carry sat", 16'h7FFF, 1'b1, 2'b01);
    check("R4 sat value", 32'(do_a), 32'h07FF);
    one("R4 R7 carry flag", 16'h7FFF, 1'b1, 2'b10);
    check("R4 flag raised", 32'(fo_a), 32'(1));
    one("R4 no carry trunc", 16'h7FFF, 1'b0, 2'b10);
    check("R4 trunc flag low", 32'(fo_a), 32'(0));
  endtask

  task automatic t_narrow();
    one("R5 hi wrap", 16'h4000, 1'b0, 2'b00);
    one("R5 lo wrap", 16'h8000, 1'b0, 2'b00);
    one("R6 hi sat", 16'h4000, 1'b0, 2'b01);
    check("R6 max", 32'(do_b), 32'h07FF);
    one("R6 lo sat", 16'h8000, 1'b0, 2'b01);
    check("R6 min", 32'(do_b), 32'h0800);
    one("R6 edge", 16'hC000, 1'b0, 2'b01);
    one("R7 hi flag", 16'h4000, 1'b0, 2'b10);
    check("R7 hi raised", 32'(fo_b), 32'(1));
    one("R7 lo flag", 16'h8000, 1'b0, 2'b10);
    one("R7 edge no flag", 16'hC000, 1'b0, 2'b10);
    check("R7 edge quiet", 32'(fo_b), 32'(0));
  endtask

  task automatic t_alt();
    one("R8 alt hi", 16'h4000, 1'b0, 2'b11);
    check("R8 as wrap", 32'(do_b), 32'h0800);
    one("R8 alt lo", 16'h8000, 1'b1, 2'b11);
  endtask

  task automatic t_invalid();
    @(negedge clk);
    din = 16'h8000; rnd = 1'b1; om = 2'b10; vld_i = 1'b0;
    for (int k = 0; k < LAT + 3; k++) begin
      @(negedge clk);
      check("R9 vld low", 32'(vo_b), 32'(0));
      check("R9 flag a low", 32'(fo_a), 32'(0));
      check("R9 flag b low", 32'(fo_b), 32'(0));
    end
  endtask

  task automatic t_stream();
    localparam int N = 24;
    logic [11:0] ya [N];
    logic [11:0] yb [N];
    logic        fa [N];
    logic        fb [N];
    logic        vv [N];
    logic [15:0] ds;
    for (int i = 0; i < N + LAT; i++) begin
      @(negedge clk);
      if (i >= LAT) begin
        check("R1 R11 stream vld", 32'(vo_a), 32'(vv[i-LAT]));
        if (vv[i-LAT]) begin
          check("R11 stream data a", 32'(do_a), 32'(ya[i-LAT]));
          check("R11 stream flag a", 32'(fo_a), 32'(fa[i-LAT]));
          check("R11 stream data b", 32'(do_b), 32'(yb[i-LAT]));
          check("R11 stream flag b", 32'(fo_b), 32'(fb[i-LAT]));
        end else begin
          check("R9 stream bubble flag", 32'(fo_b), 32'(0));
        end
      end
      if (i < N) begin
        ds = 16'(i * 16'h1B37 + 16'h7FF5);
        vv[i] = (i != 7);
        din = ds; rnd = i[0]; om = 2'(i % 4); vld_i = vv[i];
        model(ds, 4, i[0], 2'(i % 4), ya[i], fa[i]);
        model(ds, 3, i[0], 2'(i % 4), yb[i], fb[i]);
      end else begin
        vld_i = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_trunc();
    t_round();
    t_round_carry();
    t_narrow();
    t_alt();
    t_invalid();
    t_stream();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule